// File: doc/BRIEF.md
# Externally Clocked Serial Output Port

This block presents a converted word on a single serial data pin, most significant bit first, using a shift clock supplied from outside the chip. It runs from a fixed frame of master-clock cycles. Once per frame it takes a fresh parallel word from the converter core into its output register. A ready flag, active low, tells the host when a word is waiting. When the port is not selected, the data pin's pad driver is turned off, so the pin is high-impedance.

The host pulls the select line low and clocks bits out with falling edges on the serial clock. A host may also read part of a word and stop. While the host keeps the port selected with bits still unread, the register keeps its word across frame boundaries. Once the host releases select, the port loads a new word at the end of the current frame. Select and serial clock come from outside the master-clock domain, so both pass through a synchronizer before any logic uses them.

Top module: `sop_port`

## Requirements
- R1: The output register takes `conv_word` on the last cycle of every FRAME_LEN-cycle frame, unless R6 holds it off. The frame counter starts at reset, so the first word is present FRAME_LEN cycles after reset is released. `rdy_n` is low in frame phase 0, the first cycle that holds the new word.
- R2: If the port is not selected and the word is not drained, `rdy_n` is high in the last GAP_LEN phases of a frame (phases 1020 to 1023 for the default sizes) and low in all other phases.
- R3: A low on `cs_n` is recognized three cycles after it is applied: two synchronizer stages plus the select register. If it arrives during the ready-high gap, recognition waits until phase 1 of the next frame, and the word is still reloaded at the frame end.
- R4: Once select is recognized, `sdo_oe` is 1 and `sdo` shows the MSB. Each falling edge of `sclk` (after synchronization) moves `sdo` to the next lower bit. Edges on `sclk` while the port is not selected have no effect.
- R5: After the falling edge that follows the LSB, `rdy_n` goes high and `sdo_oe` goes low. Both stay that way until the next load.
- R6: While select is recognized and bits remain unread, no reload takes place and `rdy_n` stays low through the gap. Shifting then continues in the next frame, from the same word.
- R7: Raising `cs_n` drops `sdo_oe`. The unread bits are kept and resume on a later select within the same frame. `rdy_n` stays low until the gap, and the word is reloaded at the frame end.
- R8: During reset and until the first load, `rdy_n` is 1 and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_word | input | WORD_W | Parallel word from the converter core |
| cs_n | input | 1 | Asynchronous chip select, active low |
| sclk | input | 1 | External shift clock, asynchronous |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Pad drive enable for `sdo`; 0 means high-impedance |
| rdy_n | output | 1 | Word-ready flag, active low |

## Verification
The assertions assume that `sclk` and `cs_n` each stay at a level for at least three master-clock cycles. Under that condition every external edge shows up as exactly one synchronized edge, and no `sclk` fall is lost. The bench holds every `sclk` and `cs_n` level for four or more cycles. It changes `conv_word` only at phase 1000, well away from the load cycle. These limits keep the synchronizer latency fixed at the value R3 states, so the bench can predict each output change to the exact cycle.

// File: rtl/sop_pkg.sv
package sop_pkg;

   // bundle of the two asynchronous control pins, in synchronizer order
   typedef struct packed {
      logic sclk;
      logic cs_n;
   } sop_pins_t;

   localparam int SOP_PINS_W = $bits(sop_pins_t);

   // idle levels used as synchronizer reset values
   localparam sop_pins_t SOP_PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1};

endpackage

// File: rtl/sop_sync.sv
module sop_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sop_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sop_frame_timer.sv
module sop_frame_timer #(
   parameter int FRAME_LEN = 1024,
   parameter int GAP_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic frame_end,
   output logic in_gap
);

   localparam int CW = $clog2(FRAME_LEN);
   localparam logic [CW-1:0] LAST_PH = CW'(FRAME_LEN - 1);
   localparam logic [CW-1:0] GAP_PH = CW'(FRAME_LEN - GAP_LEN);
   localparam bit POW2 = ((FRAME_LEN & (FRAME_LEN - 1)) == 0);

   if (GAP_LEN < 1 || GAP_LEN >= FRAME_LEN) begin : g_bad_gap
      $error("sop_frame_timer: GAP_LEN out of range");
   end
   if (FRAME_LEN < 4) begin : g_bad_frame
      $error("sop_frame_timer: FRAME_LEN too small");
   end

   logic [CW-1:0] phase_q;
   logic [CW-1:0] phase_nxt;

   assign frame_end = (phase_q == LAST_PH);
   assign in_gap    = (phase_q >= GAP_PH);

   if (POW2) begin : g_wrap_free
      assign phase_nxt = phase_q + 1'b1;
   end else begin : g_wrap_cmp
      assign phase_nxt = frame_end ? '0 : phase_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_nxt;
   end

   // R1
   frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (phase_q == '0));

   // R2
   gap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_gap) |-> (phase_q == GAP_PH));

endmodule

// File: rtl/sop_shift_reg.sv
module sop_shift_reg #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   input  logic              step,
   output logic              bit_out,
   output logic              drained
);

   localparam int IW = $clog2(WORD_W);
   localparam logic [IW-1:0] MSB_IDX = IW'(WORD_W - 1);

   logic [WORD_W-1:0] word_q;
   logic [IW-1:0]     idx_q;
   logic              drained_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q    <= '0;
         idx_q     <= MSB_IDX;
         drained_q <= 1'b1;
      end else if (load) begin
         word_q    <= word_in;
         idx_q     <= MSB_IDX;
         drained_q <= 1'b0;
      end else if (step && !drained_q) begin
         if (idx_q == '0) drained_q <= 1'b1;
         else             idx_q     <= idx_q - 1'b1;
      end
   end

   assign bit_out = word_q[idx_q];
   assign drained = drained_q;

   // R6
   load_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && step));

   // R5
   last_bit_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !drained_q && idx_q == '0) |=> drained_q);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> ($stable(idx_q) && $stable(word_q)));

endmodule

// File: rtl/sop_port.sv
module sop_port
   import sop_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int FRAME_LEN = 1024,
   parameter int GAP_LEN = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] conv_word,
   input  logic              cs_n,
   input  logic              sclk,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              rdy_n
);

   if (WORD_W != 16 && WORD_W != 20) begin : g_bad_width
      $error("sop_port: WORD_W must be 16 or 20");
   end

   sop_pins_t pins_raw;
   sop_pins_t pins_s;
   logic      sclk_d;
   logic      sclk_fall;
   logic      sel_q;
   logic      hold;
   logic      load;
   logic      step;
   logic      frame_end;
   logic      in_gap;
   logic      drained;
   logic      bit_out;

   assign pins_raw.sclk = sclk;
   assign pins_raw.cs_n = cs_n;

   sop_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (SOP_PINS_W),
      .RST_VAL(SOP_PINS_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw),
      .q    (pins_s)
   );

   sop_frame_timer #(
      .FRAME_LEN(FRAME_LEN),
      .GAP_LEN  (GAP_LEN)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_end(frame_end),
      .in_gap   (in_gap)
   );

   // edge detect on the synchronized shift clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= pins_s.sclk;
   end
   assign sclk_fall = sclk_d & ~pins_s.sclk;

   // select: a new low is taken only outside the gap; a held select persists
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= ~pins_s.cs_n & (sel_q | ~in_gap);
   end

   assign hold = sel_q & ~drained;
   assign load = frame_end & ~hold;
   assign step = sclk_fall & hold;

   sop_shift_reg #(
      .WORD_W(WORD_W)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .word_in(conv_word),
      .step   (step),
      .bit_out(bit_out),
      .drained(drained)
   );

   assign sdo    = bit_out;
   assign sdo_oe = hold;
   assign rdy_n  = drained | (in_gap & ~hold);

   // R4
   oe_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> !rdy_n);

   // R5
   drained_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drained |-> (rdy_n && !sdo_oe));

   // R3
   gap_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_gap && !sel_q) |=> !sel_q);

   // R7
   release_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pins_s.cs_n |=> !sdo_oe);

endmodule

// File: tb/sop_port_test.sv
module sop_port_test;

   localparam int W = 16;
   localparam int F = 1024;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         sclk = 1'b0;
   logic [W-1:0] word = '0;
   logic         sdo;
   logic         oe;
   logic         rdy_n;

   int checks = 0;
   int errors = 0;
   int ph = 0;

   always #4 clk = ~clk;

   sop_port #(.WORD_W(W), .FRAME_LEN(F), .GAP_LEN(4), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .conv_word(word), .cs_n(cs_n), .sclk(sclk),
      .sdo(sdo), .sdo_oe(oe), .rdy_n(rdy_n)
   );

   // expected frame phase, counted from reset release
   always @(posedge clk) begin
      if (!rst_n) ph <= 0;
      else        ph <= (ph + 1) % F;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at phase %0d: actual %h expected %h", req, ph, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ph(input int k);
      do @(negedge clk); while (ph != k);
   endtask

   task automatic shift_bit(input logic e, input string req);
      sclk = 1'b1;
      idle(4);
      chk(oe === 1'b1 && sdo === e, req, {30'd0, oe, sdo}, {30'd0, 1'b1, e});
      sclk = 1'b0;
      idle(4);
   endtask

   task automatic read_seq(input logic [W-1:0] w, input int hi, input int n, input string req);
      for (int i = 0; i < n; i++) shift_bit(w[hi-i], req);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [W-1:0] pat;
      logic [W-1:0] held;
      // R8 reset state
      idle(3);
      chk(rdy_n === 1'b1, "R8", {31'd0, rdy_n}, 32'd1);
      chk(oe === 1'b0, "R8", {31'd0, oe}, 32'd0);
      word = 16'hA5C3;
      rst_n = 1'b1;
      wait_ph(1023);
      chk(rdy_n === 1'b1 && oe === 1'b0, "R8", {30'd0, rdy_n, oe}, 32'd2);
      wait_ph(0);
      chk(rdy_n === 1'b0, "R1", {31'd0, rdy_n}, 32'd0);

      // R2 frame with no read
      wait_ph(1019);
      chk(rdy_n === 1'b0, "R2", {31'd0, rdy_n}, 32'd0);
      wait_ph(1020);
      chk(rdy_n === 1'b1, "R2", {31'd0, rdy_n}, 32'd1);
      wait_ph(1023);
      chk(rdy_n === 1'b1, "R2", {31'd0, rdy_n}, 32'd1);
      wait_ph(0);
      chk(rdy_n === 1'b0, "R1", {31'd0, rdy_n}, 32'd0);

      // R4/R5 sweep over full reads of varied words
      for (int k = 0; k < 8; k++) begin
         pat = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 :
               ((16'h1 << (2 * k)) ^ (16'(k) * 16'h1357));
         wait_ph(1000);
         word = pat;
         wait_ph(8);
         cs_n = 1'b0;
         wait_ph(10);
         chk(oe === 1'b0, "R3", {31'd0, oe}, 32'd0);
         wait_ph(11);
         chk(oe === 1'b1 && sdo === pat[W-1], "R4", {30'd0, oe, sdo}, {30'd0, 1'b1, pat[W-1]});
         read_seq(pat, W - 1, W, "R4");
         chk(rdy_n === 1'b1 && oe === 1'b0, "R5", {30'd0, rdy_n, oe}, 32'd2);
         cs_n = 1'b1;
      end

      // R6 partial read held across a frame boundary
      held = 16'hC3A5;
      wait_ph(1000);
      word = held;
      wait_ph(8);
      cs_n = 1'b0;
      idle(5);
      read_seq(held, 15, 5, "R6");
      wait_ph(1000);
      word = 16'h5A3C;
      wait_ph(1021);
      chk(rdy_n === 1'b0, "R6", {31'd0, rdy_n}, 32'd0);
      wait_ph(5);
      chk(oe === 1'b1 && sdo === held[10], "R6", {30'd0, oe, sdo}, {30'd0, 1'b1, held[10]});
      read_seq(held, 10, 11, "R6");
      chk(rdy_n === 1'b1 && oe === 1'b0, "R5", {30'd0, rdy_n, oe}, 32'd2);
      cs_n = 1'b1;

      // R7 release mid-read, sclk ignored while released, resume
      wait_ph(8);
      cs_n = 1'b0;
      idle(5);
      read_seq(16'h5A3C, 15, 4, "R7");
      cs_n = 1'b1;
      idle(5);
      chk(oe === 1'b0, "R7", {31'd0, oe}, 32'd0);
      for (int t = 0; t < 2; t++) begin
         sclk = 1'b1; idle(4); sclk = 1'b0; idle(4);
      end
      wait_ph(500);
      chk(rdy_n === 1'b0, "R7", {31'd0, rdy_n}, 32'd0);
      cs_n = 1'b0;
      idle(5);
      chk(oe === 1'b1 && sdo === 1'b1, "R7", {30'd0, oe, sdo}, 32'd3);
      cs_n = 1'b1;
      wait_ph(1000);
      word = 16'h9E01;
      wait_ph(1020);
      chk(rdy_n === 1'b1, "R7", {31'd0, rdy_n}, 32'd1);

      // R3 select applied inside the gap
      cs_n = 1'b0;
      wait_ph(1023);
      chk(oe === 1'b0 && rdy_n === 1'b1, "R3", {30'd0, rdy_n, oe}, 32'd2);
      wait_ph(0);
      chk(oe === 1'b0, "R3", {31'd0, oe}, 32'd0);
      wait_ph(1);
      chk(oe === 1'b1 && sdo === 1'b1, "R3", {30'd0, oe, sdo}, 32'd3);
      read_seq(16'h9E01, 15, W, "R1");
      chk(rdy_n === 1'b1 && oe === 1'b0, "R5", {30'd0, rdy_n, oe}, 32'd2);
      cs_n = 1'b1;
      idle(5);
      finish_run();
   end

endmodule